// File: doc/BRIEF.md
# Trace Qualification Filter

This block decides, one retired-instruction record at a time, whether the record coming from a trace ingress port should be traced. It holds a small bank of filters and a small bank of comparator units. Software sets them up through a write-only configuration port.

Each filter can require any of three conditions:
- The privilege level of the record is selected in an 8-bit choice bitmap.
- The exception cause of the record is selected in a 64-bit cause bitmap.
- A chosen comparator unit reports that a selected record field lies inside its range.

A comparator unit pairs a lower-bound primary value with an upper-bound secondary value. It compares unsigned, and it uses only as many bits as the selected field is wide.

The block reports a hit flag for each filter and one combined trace-enable. Both are registered, so they appear one clock after the record they describe. When no filter is enabled, every valid record is traced. When some filter is enabled, a record is traced only if some enabled filter hits.

Top module: `tf_trace_filter`

## Requirements
- R1: While reset is asserted, and after it is released, all filter and comparator settings are cleared, and `filt_hit` and `trace_en` read 0.
- R2: The decision for a record offered in a cycle appears on `filt_hit`/`trace_en` after the next rising clock edge. A cycle with `rec_valid` low yields `trace_en` = 0 and `filt_hit` = 0. A configuration write in the same cycle as a record takes effect only for later records.
- R3: When no filter has its enable bit set, every valid record gives `trace_en` = 1.
- R4: Bit 0 of a filter control word (offset 0x400 + 0x20*i) enables filter i. A disabled filter never hits. An enabled filter with none of its condition bits set hits on every valid record.
- R5: When bit 1 of the filter control word is set, the filter requires that bit `rec_priv` of the privilege bitmap (offset +0x004, bits 7..0) be 1.
- R6: When bit 2 of the filter control word is set, the filter requires a set bit in the cause bitmap. Bit N of the word at +0x008 selects cause N. Bit N of the word at +0x00C selects cause N+32.
- R7: When bit 3 of the filter control word is set, the filter requires a hit from comparator unit k, where k is control bits 11..8. A unit hits when its selected field is at least the primary value and strictly below the secondary value, compared unsigned.
- R8: Comparator unit j has its control word at 0x600 + 0x20*j, with bit 0 choosing the field: 0 = `rec_iaddr`, 1 = `rec_cause`. Its 64-bit primary value sits at +0x010/+0x014 (low/high) and its secondary value at +0x018/+0x01C. Only the low bits matching the selected field's width take part; all higher bits of the values are ignored.
- R9: A filter hits only when all of its enabled conditions hold. When at least one filter is enabled, `trace_en` is the OR of the filter hits.
- R10: A range condition that names a comparator index not present in the block never holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Byte offset of the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| rec_valid | input | 1 | Ingress record present this cycle |
| rec_priv | input | 3 | Privilege code of the record |
| rec_cause | input | 6 | Exception cause of the record |
| rec_iaddr | input | IADDR_W | Instruction address of the record |
| filt_hit | output | NUM_FILT | Registered per-filter hit |
| trace_en | output | 1 | Registered combined trace decision |

## Verification
The hardest cases to reach are the width masking and the bitmap boundaries.

For the masking, the comparator's high match bits must be junk while the field under test sits right at the low-bit bounds. The stimulus loads primary and secondary values with nonzero bits above the field width, then sweeps every cause code and the addresses one step either side of each bound. Every cause from 0 to 63 is also swept against a bitmap with one bit set in each half, which exposes any off-by-32 slip.

A pseudo-random stretch then mixes all three conditions across two filters. Within that stretch, configuration writes land in the same cycle as valid records.

// File: rtl/tf_pkg.sv
package tf_pkg;

    localparam int PRIV_W  = 3;
    localparam int CAUSE_W = 6;
    localparam int SEL_W   = 4;
    localparam int VAL_W   = 64;

    typedef struct packed {
        logic                  en;
        logic                  use_priv;
        logic                  use_cause;
        logic                  use_range;
        logic [SEL_W-1:0]      cmp_sel;
        logic [2**PRIV_W-1:0]  priv_map;
        logic [2**CAUSE_W-1:0] cause_map;
    } filt_cfg_t;

    typedef struct packed {
        logic             sel_cause;
        logic [VAL_W-1:0] lo_val;
        logic [VAL_W-1:0] hi_val;
    } cmp_cfg_t;

endpackage

// File: rtl/tf_cfg_regs.sv
module tf_cfg_regs
    import tf_pkg::*;
#(
    parameter int NUM_FILT = 2,
    parameter int NUM_CMP  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [11:0]               cfg_addr,
    input  logic [31:0]               cfg_wdata,
    output filt_cfg_t [NUM_FILT-1:0]  filt_cfg,
    output cmp_cfg_t  [NUM_CMP-1:0]   cmp_cfg
);

    typedef struct packed {
        filt_cfg_t [NUM_FILT-1:0] filt;
        cmp_cfg_t  [NUM_CMP-1:0]  cmp;
    } regs_t;

    regs_t regs_d, regs_q;

    logic       in_filt, in_cmp;
    logic [3:0] unit_idx;
    logic [2:0] word_idx;

    assign in_filt  = cfg_we && (cfg_addr[11:9] == 3'b010);
    assign in_cmp   = cfg_we && (cfg_addr[11:9] == 3'b011);
    assign unit_idx = cfg_addr[8:5];
    assign word_idx = cfg_addr[4:2];

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_FILT; i++) begin
            if (in_filt && unit_idx == 4'(i)) begin
                case (word_idx)
                    3'd0: begin
                        regs_d.filt[i].en        = cfg_wdata[0];
                        regs_d.filt[i].use_priv  = cfg_wdata[1];
                        regs_d.filt[i].use_cause = cfg_wdata[2];
                        regs_d.filt[i].use_range = cfg_wdata[3];
                        regs_d.filt[i].cmp_sel   = cfg_wdata[11:8];
                    end
                    3'd1: regs_d.filt[i].priv_map         = cfg_wdata[7:0];
                    3'd2: regs_d.filt[i].cause_map[31:0]  = cfg_wdata;
                    3'd3: regs_d.filt[i].cause_map[63:32] = cfg_wdata;
                    default: ;
                endcase
            end
        end
        for (int j = 0; j < NUM_CMP; j++) begin
            if (in_cmp && unit_idx == 4'(j)) begin
                case (word_idx)
                    3'd0: regs_d.cmp[j].sel_cause     = cfg_wdata[0];
                    3'd4: regs_d.cmp[j].lo_val[31:0]  = cfg_wdata;
                    3'd5: regs_d.cmp[j].lo_val[63:32] = cfg_wdata;
                    3'd6: regs_d.cmp[j].hi_val[31:0]  = cfg_wdata;
                    3'd7: regs_d.cmp[j].hi_val[63:32] = cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign filt_cfg = regs_q.filt;
    assign cmp_cfg  = regs_q.cmp;

endmodule

// File: rtl/tf_range_cmp.sv
module tf_range_cmp
    import tf_pkg::*;
#(
    parameter int IADDR_W = 32
) (
    input  cmp_cfg_t             cfg,
    input  logic [IADDR_W-1:0]   iaddr,
    input  logic [CAUSE_W-1:0]   cause,
    output logic                 hit
);

    logic addr_in, cause_in;

    // Each field is compared only over its own width; upper value bits drop out.
    always_comb begin
        addr_in  = (iaddr >= cfg.lo_val[IADDR_W-1:0]) &&
                   (iaddr <  cfg.hi_val[IADDR_W-1:0]);
        cause_in = (cause >= cfg.lo_val[CAUSE_W-1:0]) &&
                   (cause <  cfg.hi_val[CAUSE_W-1:0]);
        hit      = cfg.sel_cause ? cause_in : addr_in;
    end

endmodule

// File: rtl/tf_filter_unit.sv
module tf_filter_unit
    import tf_pkg::*;
#(
    parameter int NUM_CMP = 2
) (
    input  filt_cfg_t            cfg,
    input  logic [PRIV_W-1:0]    priv,
    input  logic [CAUSE_W-1:0]   cause,
    input  logic [NUM_CMP-1:0]   cmp_hits,
    output logic                 hit
);

    logic priv_ok, cause_ok, range_ok, range_sel;

    always_comb begin
        range_sel = 1'b0;
        for (int j = 0; j < NUM_CMP; j++) begin
            if (cfg.cmp_sel == SEL_W'(j)) range_sel = cmp_hits[j];
        end
        priv_ok  = !cfg.use_priv  || cfg.priv_map[priv];
        cause_ok = !cfg.use_cause || cfg.cause_map[cause];
        range_ok = !cfg.use_range || range_sel;
        hit      = cfg.en && priv_ok && cause_ok && range_ok;
    end

endmodule

// File: rtl/tf_trace_filter.sv
module tf_trace_filter
    import tf_pkg::*;
#(
    parameter int NUM_FILT = 2,
    parameter int NUM_CMP  = 2,
    parameter int IADDR_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [11:0]          cfg_addr,
    input  logic [31:0]          cfg_wdata,
    input  logic                 rec_valid,
    input  logic [2:0]           rec_priv,
    input  logic [5:0]           rec_cause,
    input  logic [IADDR_W-1:0]   rec_iaddr,
    output logic [NUM_FILT-1:0]  filt_hit,
    output logic                 trace_en
);

    typedef struct packed {
        logic [NUM_FILT-1:0] hit;
        logic                en;
    } dec_t;

    filt_cfg_t [NUM_FILT-1:0] filt_cfg_w;
    cmp_cfg_t  [NUM_CMP-1:0]  cmp_cfg_w;
    logic      [NUM_CMP-1:0]  cmp_hit_w;
    logic      [NUM_FILT-1:0] raw_hit_w;
    logic      [NUM_FILT-1:0] filt_en_w;
    dec_t                     dec_d, dec_q;

    tf_cfg_regs #(.NUM_FILT(NUM_FILT), .NUM_CMP(NUM_CMP)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .filt_cfg  (filt_cfg_w),
        .cmp_cfg   (cmp_cfg_w)
    );

    for (genvar j = 0; j < NUM_CMP; j++) begin : g_cmp
        tf_range_cmp #(.IADDR_W(IADDR_W)) u_cmp (
            .cfg   (cmp_cfg_w[j]),
            .iaddr (rec_iaddr),
            .cause (rec_cause),
            .hit   (cmp_hit_w[j])
        );
    end

    for (genvar i = 0; i < NUM_FILT; i++) begin : g_filt
        tf_filter_unit #(.NUM_CMP(NUM_CMP)) u_filt (
            .cfg      (filt_cfg_w[i]),
            .priv     (rec_priv),
            .cause    (rec_cause),
            .cmp_hits (cmp_hit_w),
            .hit      (raw_hit_w[i])
        );
        assign filt_en_w[i] = filt_cfg_w[i].en;
    end

    always_comb begin
        dec_d.hit = rec_valid ? raw_hit_w : '0;
        dec_d.en  = rec_valid && ((filt_en_w == '0) || (raw_hit_w != '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign filt_hit = dec_q.hit;
    assign trace_en = dec_q.en;

endmodule

// File: rtl/tf_trace_filter_chk.sv
module tf_trace_filter_chk #(
    parameter int NUM_FILT = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rec_valid,
    input logic [NUM_FILT-1:0] filt_en,
    input logic [NUM_FILT-1:0] filt_hit,
    input logic                trace_en
);

    // R1: outputs stay cleared across a reset cycle
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!trace_en && filt_hit == '0));

    // R2: an empty ingress slot produces a quiet decision
    a_r2_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_valid |=> (!trace_en && filt_hit == '0));

    // R3: with nothing enabled every valid record passes
    a_r3_all_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && filt_en == '0) |=> trace_en);

    // R4: a disabled filter never reports a hit
    for (genvar i = 0; i < NUM_FILT; i++) begin : g_off
        a_r4_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
            !filt_en[i] |=> !filt_hit[i]);
    end

    // R9: any hit raises the trace decision
    a_r9_hit_implies_en: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_hit != '0) |-> trace_en);

    // R9: with some filter enabled the decision equals the OR of hits
    a_r9_or_of_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en != '0) |=> (trace_en == (filt_hit != '0)));

endmodule

bind tf_trace_filter tf_trace_filter_chk #(.NUM_FILT(NUM_FILT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_valid (rec_valid),
    .filt_en   (filt_en_w),
    .filt_hit  (filt_hit),
    .trace_en  (trace_en)
);

// File: tb/tf_trace_filter_tb.sv
`timescale 1ns/1ps
module tf_trace_filter_tb;

    localparam int NF  = 2;
    localparam int NC  = 2;
    localparam int IAW = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [11:0]    cfg_addr = '0;
    logic [31:0]    cfg_wdata = '0;
    logic           rec_valid = 1'b0;
    logic [2:0]     rec_priv = '0;
    logic [5:0]     rec_cause = '0;
    logic [IAW-1:0] rec_iaddr = '0;
    logic [NF-1:0]  filt_hit;
    logic           trace_en;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    logic [31:0] lfsr = 32'hACE1_1234;

    // behavioural configuration model
    logic        m_en[NF], m_up[NF], m_uc[NF], m_ur[NF];
    logic [3:0]  m_sel[NF];
    logic [7:0]  m_pmap[NF];
    logic [63:0] m_cmap[NF];
    logic        m_csel[NC];
    logic [63:0] m_lo[NC], m_hi[NC];

    always #2.5 clk = ~clk;

    tf_trace_filter #(.NUM_FILT(NF), .NUM_CMP(NC), .IADDR_W(IAW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rec_valid(rec_valid), .rec_priv(rec_priv),
        .rec_cause(rec_cause), .rec_iaddr(rec_iaddr),
        .filt_hit(filt_hit), .trace_en(trace_en)
    );

    initial begin
        #1_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog %s: actual=timeout expected=finish", cur_req);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    function automatic void m_clear();
        for (int f = 0; f < NF; f++) begin
            m_en[f] = 0; m_up[f] = 0; m_uc[f] = 0; m_ur[f] = 0;
            m_sel[f] = '0; m_pmap[f] = '0; m_cmap[f] = '0;
        end
        for (int j = 0; j < NC; j++) begin
            m_csel[j] = 0; m_lo[j] = '0; m_hi[j] = '0;
        end
    endfunction

    function automatic void m_write(input logic [11:0] a, input logic [31:0] d);
        int u, o;
        if (a >= 12'h400 && a < 12'h600) begin
            u = (int'(a) - 'h400) / 32; o = (int'(a) - 'h400) % 32;
            if (u < NF) begin
                case (o)
                    0:  begin m_en[u] = d[0]; m_up[u] = d[1]; m_uc[u] = d[2];
                              m_ur[u] = d[3]; m_sel[u] = d[11:8]; end
                    4:  m_pmap[u] = d[7:0];
                    8:  m_cmap[u][31:0]  = d;
                    12: m_cmap[u][63:32] = d;
                    default: ;
                endcase
            end
        end else if (a >= 12'h600 && a < 12'h800) begin
            u = (int'(a) - 'h600) / 32; o = (int'(a) - 'h600) % 32;
            if (u < NC) begin
                case (o)
                    0:  m_csel[u] = d[0];
                    16: m_lo[u][31:0]  = d;
                    20: m_lo[u][63:32] = d;
                    24: m_hi[u][31:0]  = d;
                    28: m_hi[u][63:32] = d;
                    default: ;
                endcase
            end
        end
    endfunction

    function automatic logic in_range(input int j, input logic [5:0] c,
                                      input logic [IAW-1:0] ia);
        int w;
        logic [63:0] mask, x;
        w    = m_csel[j] ? 6 : IAW;
        mask = (64'd1 << w) - 64'd1;
        x    = m_csel[j] ? 64'(c) : 64'(ia);
        return (x >= (m_lo[j] & mask)) && (x < (m_hi[j] & mask));
    endfunction

    function automatic void model(input logic v, input logic [2:0] p,
                                  input logic [5:0] c, input logic [IAW-1:0] ia,
                                  output logic [NF-1:0] eh, output logic ee);
        logic any_on, ok;
        any_on = 0; eh = '0;
        for (int f = 0; f < NF; f++) begin
            if (m_en[f]) begin
                any_on = 1; ok = 1;
                if (m_up[f] && !m_pmap[f][p]) ok = 0;
                if (m_uc[f] && !m_cmap[f][c]) ok = 0;
                if (m_ur[f]) begin
                    if (int'(m_sel[f]) >= NC) ok = 0;
                    else if (!in_range(int'(m_sel[f]), c, ia)) ok = 0;
                end
                eh[f] = v && ok;
            end
        end
        ee = v && (!any_on || eh != '0);
    endfunction

    task automatic compare(input logic [NF-1:0] eh, input logic ee);
        n_checks++;
        if (filt_hit !== eh || trace_en !== ee) begin
            n_fail++;
            $display("FAIL %s: actual hit=%b en=%b expected hit=%b en=%b",
                     cur_req, filt_hit, trace_en, eh, ee);
        end
    endtask

    // one clock: optional write plus optional record, compared after the edge
    task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d,
                        input logic v, input logic [2:0] p, input logic [5:0] c,
                        input logic [IAW-1:0] ia);
        logic [NF-1:0] eh;
        logic ee;
        @(negedge clk);
        cfg_we = we; cfg_addr = a; cfg_wdata = d;
        rec_valid = v; rec_priv = p; rec_cause = c; rec_iaddr = ia;
        model(v, p, c, ia, eh, ee);
        if (we) m_write(a, d);
        @(posedge clk); #1;
        compare(eh, ee);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(1'b1, a, d, 1'b0, 3'd0, 6'd0, '0);
    endtask

    task automatic rec(input logic [2:0] p, input logic [5:0] c, input logic [IAW-1:0] ia);
        step(1'b0, 12'h0, 32'h0, 1'b1, p, c, ia);
    endtask

    function automatic logic [31:0] next_lfsr(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    initial begin
        m_clear();
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #1;
        compare('0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        compare('0, 1'b0);

        // R3 and R2: no filter enabled, mix of valid and empty slots
        cur_req = "R3";
        for (int k = 0; k < 8; k++) rec(3'(k), 6'(k * 7), 32'(k * 32'h1111));
        cur_req = "R2";
        for (int k = 0; k < 4; k++) step(1'b0, 12'h0, 32'h0, 1'b0, 3'(k), 6'(k), 32'(k));

        // R4: filter 0 enabled with no conditions, filter 1 off
        cur_req = "R4";
        wr(12'h400, 32'h1);
        for (int k = 0; k < 6; k++) rec(3'(k), 6'(k * 9), 32'(k * 32'h0100_0001));
        step(1'b0, 12'h0, 32'h0, 1'b0, 3'd1, 6'd1, 32'd1);

        // R5: privilege bitmap selects codes 1 and 3
        cur_req = "R5";
        wr(12'h404, 32'hFFFF_FF0A);
        wr(12'h400, 32'h3);
        for (int k = 0; k < 8; k++) rec(3'(k), 6'd0, 32'h0);

        // R6: cause 5 in the low word, cause 35 in the high word
        cur_req = "R6";
        wr(12'h408, 32'h0000_0020);
        wr(12'h40C, 32'h0000_0008);
        wr(12'h400, 32'h5);
        for (int k = 0; k < 64; k++) rec(3'd0, 6'(k), 32'h0);

        // R7: comparator 0 on address, [0x1000, 0x2000) with junk high words
        cur_req = "R7";
        wr(12'h400, 32'h0);
        wr(12'h600, 32'h0);
        wr(12'h610, 32'h0000_1000);
        wr(12'h614, 32'hDEAD_BEEF);
        wr(12'h618, 32'h0000_2000);
        wr(12'h61C, 32'h0000_0001);
        wr(12'h420, 32'h0000_0009);
        rec(3'd0, 6'd0, 32'h0000_0FFF);
        rec(3'd0, 6'd0, 32'h0000_1000);
        rec(3'd0, 6'd0, 32'h0000_1FFF);
        rec(3'd0, 6'd0, 32'h0000_2000);
        rec(3'd0, 6'd0, 32'hFFFF_FFFF);
        rec(3'd0, 6'd0, 32'h8000_1800);

        // R8: comparator 1 on cause, low bits give [10, 20), upper bits junk
        cur_req = "R8";
        wr(12'h620, 32'h1);
        wr(12'h630, 32'hFFFF_FF0A);
        wr(12'h634, 32'h1234_5678);
        wr(12'h638, 32'h0000_0F94);
        wr(12'h63C, 32'hFFFF_FFFF);
        wr(12'h400, 32'h0000_0109);
        for (int k = 0; k < 64; k++) rec(3'd2, 6'(k), 32'h0000_1500);

        // R10: range condition pointing at an absent comparator
        cur_req = "R10";
        wr(12'h420, 32'h0000_0509);
        for (int k = 0; k < 6; k++) rec(3'(k), 6'(k + 10), 32'h0000_1100);

        // R9: AND within filters, OR across them, writes mixed with records
        cur_req = "R9";
        wr(12'h404, 32'h0000_000F);
        wr(12'h408, 32'hFFFF_0000);
        wr(12'h40C, 32'h0000_0000);
        wr(12'h400, 32'h0000_0007);
        wr(12'h420, 32'h0000_0009);
        for (int k = 0; k < 300; k++) begin
            lfsr = next_lfsr(lfsr);
            if (k % 37 == 5)
                step(1'b1, 12'h408, lfsr, 1'b1, lfsr[2:0], lfsr[8:3],
                     {18'd0, lfsr[21:8]});
            else
                step(1'b0, 12'h0, 32'h0, lfsr[31] | lfsr[30], lfsr[2:0], lfsr[8:3],
                     {18'd0, lfsr[21:8]});
        end

        // R2: configuration written in the same cycle as a record
        cur_req = "R2";
        wr(12'h420, 32'h0);
        step(1'b1, 12'h400, 32'h0, 1'b1, 3'd7, 6'd0, 32'h0);
        rec(3'd7, 6'd0, 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule